// File: doc/BRIEF.md
# Two-wire host register slave for a card interface

This block lets a host processor drive a smart-card interface over a two-wire serial bus (I2C). It answers on one of eight 7-bit addresses, chosen by three select pins. It holds a single control byte that the host writes and a single status byte that the host reads. There is no register pointer. A transfer in the write direction always lands in the control byte, and a transfer in the read direction always returns the status byte.

The status byte combines live levels with event flags that latch. The live levels are card presence, card data line level and session active. The latched flags are presence change, supply fault, protection fault, mute answer and early answer. An active-low interrupt stays asserted while any latched flag is set or a supply fault is present. A completed status read clears exactly the flags that the read reported. After a supply fault ends, the interrupt is held for a programmable settling window. SCL and SDA are oversampled by the system clock, and a filter suppresses short spikes on both lines.

Top module: `cifh_host_regs`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal BASE_ADDR7 OR sel_i (default 0x20..0x27, written 0x40..0x4E with the R/W bit in bit 0). Any other address gets no acknowledge and has no effect on the control byte or on any latched flag.
- R2: A write (R/W=0) stores the one data byte that follows into ctrl_o and acknowledges it. ctrl_o is 0x00 after reset and changes at no other time.
- R3: A read (R/W=1) returns the status byte MSB first. The bits are: 7 active_i, 6 early flag, 5 mute flag, 4 protection flag, 3 supply flag, 2 io_lvl_i, 1 presence-change flag, 0 pres_i.
- R4: Any change of pres_i sets the presence-change flag. A completed read that reported the flag clears it.
- R5: sup_fault_i high sets the supply flag and pulls irq_n_o low. After sup_fault_i falls, irq_n_o stays low for HOLD_CYC clock cycles even when no flag is set.
- R6: prot_fault_i high sets the protection flag. A completed read that reported the flag clears it.
- R7: A pulse on mute_i or early_i sets its flag. The flag clears on a completed read that reported it, or when a write raises control bit 0 from 0 to 1 (session start).
- R8: irq_n_o is low while any latched flag is set. It returns high once a status read clears the last flag and no supply hold is pending.
- R9: An event that arrives after the status byte was captured, or in the same cycle as the clear, stays latched for the next read.
- R10: A pulse shorter than FILT_CYC clock cycles on SCL or SDA is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sel_i | input | 3 | Address select pins |
| pres_i | input | 1 | Card present level |
| io_lvl_i | input | 1 | Card data line level |
| active_i | input | 1 | Card session active level |
| sup_fault_i | input | 1 | Supply fault level |
| prot_fault_i | input | 1 | Over-current or over-heat fault level |
| mute_i | input | 1 | Mute answer event pulse |
| early_i | input | 1 | Early answer event pulse |
| ctrl_o | output | 8 | Control byte |
| sda_pull_o | output | 1 | Pulls SDA low when high |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench keeps the default FILT_CYC of 13, so a 5-cycle spike on SCL in the middle of a data byte falls inside the rejection window. HOLD_CYC is lowered to 5000. At that value a full status read ends inside the supply hold window, and the expiry of the window can also be reached within the run. The select pins are drawn at random, so several of the eight addresses are tried against both matching and non-matching targets. A protection pulse injected after the address phase of a read checks that an event arriving after the status capture stays latched.

// File: rtl/cifh_pkg.sv
package cifh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } bus_st_e;

  // status byte positions of the latched flags (clear-on-read mask)
  localparam logic [7:0] STAT_CLR_MASK = 8'b0111_1010;
endpackage

// File: rtl/cifh_line_filter.sv
module cifh_line_filter #(
  parameter int FILT_CYC = 13,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (sync_q[1] != out_q) begin
      if (cnt_q == CW'(FILT_CYC - 1)) out_d = sync_q[1];
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      out_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], line_i};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;

  // R10: the output only moves once the new level has persisted long enough
  p_filt_persist_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ($past(cnt_q) == CW'(FILT_CYC - 1)));
endmodule

// File: rtl/cifh_bus_engine.sv
module cifh_bus_engine
  import cifh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [6:0] dev_addr,
  input  logic [7:0] status_i,
  output logic       ctrl_stb_o,
  output logic [7:0] ctrl_data_o,
  output logic       rd_done_o,
  output logic [7:0] rd_snap_o,
  output logic       sda_pull_o
);
  bus_st_e    st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, snap_q, snap_d;
  logic       stb_q, stb_d, rdn_q, rdn_d;
  logic       scl_q, sda_q;

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    snap_d = snap_q;
    stb_d  = 1'b0;
    rdn_d  = 1'b0;
    if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_f};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (st_q == ST_WDAT) begin
              stb_d = 1'b1;
              st_d  = ST_WACK;
            end else if (sh_q[7:1] == dev_addr) begin
              st_d = ST_AACK;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_d = '0;
          if (sh_q[0]) begin
            st_d   = ST_RDAT;
            sh_d   = status_i;
            snap_d = status_i;
          end else begin
            st_d = ST_WDAT;
          end
        end
        ST_WACK: if (scl_fall) st_d = ST_SKIP;
        ST_RDAT: if (scl_fall) begin
          if (cnt_q == 4'd7) st_d = ST_RACK;
          else begin
            sh_d  = {sh_q[6:0], 1'b1};
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_RACK: if (scl_rise) begin
          rdn_d = 1'b1;
          st_d  = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      snap_q <= '0;
      stb_q  <= 1'b0;
      rdn_q  <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      snap_q <= snap_d;
      stb_q  <= stb_d;
      rdn_q  <= rdn_d;
      scl_q  <= scl_f;
      sda_q  <= sda_f;
    end
  end

  assign ctrl_stb_o  = stb_q;
  assign ctrl_data_o = sh_q;
  assign rd_done_o   = rdn_q;
  assign rd_snap_o   = snap_q;
  assign sda_pull_o  = (st_q == ST_AACK) | (st_q == ST_WACK) |
                       ((st_q == ST_RDAT) & ~sh_q[7]);

  // R2: a control store happens only as the data byte ends
  p_store_at_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb_o |-> (st_q == ST_WACK));
  // R3: a read completes once per transfer
  p_read_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_o |=> !rd_done_o);
  // R1: the bus is never pulled low while idle
  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_pull_o);
endmodule

// File: rtl/cifh_event_regs.sv
module cifh_event_regs
  import cifh_pkg::*;
#(
  parameter int HOLD_CYC = 127500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pres_i,
  input  logic       io_lvl_i,
  input  logic       active_i,
  input  logic       sup_fault_i,
  input  logic       prot_fault_i,
  input  logic       mute_i,
  input  logic       early_i,
  input  logic       session_start_i,
  input  logic       rd_done_i,
  input  logic [7:0] rd_snap_i,
  output logic [7:0] status_o,
  output logic       irq_n_o
);
  localparam int NFLG = 5;
  localparam int HW   = $clog2(HOLD_CYC + 1);

  logic [NFLG-1:0] lat_q, lat_d, evt, clr;
  logic [7:0]      snap_m;
  logic            pres_q;
  logic [HW-1:0]   hold_q, hold_d;
  logic            hold_busy;

  // flag index: 0 presence change, 1 supply, 2 protection, 3 mute, 4 early
  assign evt    = {early_i, mute_i, prot_fault_i, sup_fault_i, pres_i ^ pres_q};
  assign snap_m = rd_snap_i & STAT_CLR_MASK & {8{rd_done_i}};
  assign clr    = {snap_m[6] | session_start_i, snap_m[5] | session_start_i,
                   snap_m[4], snap_m[3], snap_m[1]};
  assign lat_d  = (lat_q & ~clr) | evt;

  always_comb begin
    hold_d = hold_q;
    if (sup_fault_i)       hold_d = HW'(HOLD_CYC);
    else if (hold_q != '0) hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      pres_q <= 1'b0;
      hold_q <= '0;
    end else begin
      lat_q  <= lat_d;
      pres_q <= pres_i;
      hold_q <= hold_d;
    end
  end

  assign hold_busy = (hold_q != '0);
  assign status_o  = {active_i, lat_q[4], lat_q[3], lat_q[2], lat_q[1],
                      io_lvl_i, lat_q[0], pres_i};
  assign irq_n_o   = ~((|lat_q) | sup_fault_i | hold_busy);

  // R9: an event is never dropped, even against a clear in the same cycle
  for (genvar k = 0; k < NFLG; k++) begin : g_keep
    p_event_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt[k] |=> lat_q[k]);
  end
  // R5: the interrupt is still held as the supply fault goes away
  p_supply_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sup_fault_i) |-> !irq_n_o);
endmodule

// File: rtl/cifh_host_regs.sv
module cifh_host_regs #(
  parameter logic [6:0] BASE_ADDR7 = 7'h20,
  parameter int         SEL_W      = 3,
  parameter int         FILT_CYC   = 13,
  parameter int         HOLD_CYC   = 127500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pres_i,
  input  logic             io_lvl_i,
  input  logic             active_i,
  input  logic             sup_fault_i,
  input  logic             prot_fault_i,
  input  logic             mute_i,
  input  logic             early_i,
  output logic [7:0]       ctrl_o,
  output logic             sda_pull_o,
  output logic             irq_n_o
);
  localparam int PAD_W = 7 - SEL_W;

  logic       scl_f, sda_f;
  logic [6:0] dev_addr;
  logic       ctrl_stb, rd_done, session_start;
  logic [7:0] ctrl_wdata, rd_snap, status;
  logic [7:0] ctrl_q, ctrl_d;

  assign dev_addr = BASE_ADDR7 | {{PAD_W{1'b0}}, sel_i};

  logic [1:0] lines_raw, lines_flt;
  assign lines_raw = {sda_i, scl_i};
  for (genvar i = 0; i < 2; i++) begin : g_filt
    cifh_line_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_flt (
      .clk(clk), .rst_n(rst_n), .line_i(lines_raw[i]), .line_o(lines_flt[i]));
  end
  assign scl_f = lines_flt[0];
  assign sda_f = lines_flt[1];

  cifh_bus_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .dev_addr(dev_addr), .status_i(status),
    .ctrl_stb_o(ctrl_stb), .ctrl_data_o(ctrl_wdata),
    .rd_done_o(rd_done), .rd_snap_o(rd_snap), .sda_pull_o(sda_pull_o));

  assign session_start = ctrl_stb & ctrl_wdata[0] & ~ctrl_q[0];

  cifh_event_regs #(.HOLD_CYC(HOLD_CYC)) u_evt (
    .clk(clk), .rst_n(rst_n), .pres_i(pres_i), .io_lvl_i(io_lvl_i),
    .active_i(active_i), .sup_fault_i(sup_fault_i), .prot_fault_i(prot_fault_i),
    .mute_i(mute_i), .early_i(early_i), .session_start_i(session_start),
    .rd_done_i(rd_done), .rd_snap_i(rd_snap), .status_o(status),
    .irq_n_o(irq_n_o));

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_stb) ctrl_d = ctrl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 8'h00;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R2: the control byte moves only on a completed write
  p_ctrl_write_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_stb |=> $stable(ctrl_q));
endmodule

// File: tb/sim_cifh_host_regs.sv
module sim_cifh_host_regs;
  localparam int Q    = 25;
  localparam int HOLD = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1, sda_line;
  logic [2:0] sel = 3'd4;
  logic pres = 0, io = 1, act = 0, supf = 0, protf = 0, mute = 0, early = 0;
  logic [7:0] ctrl;
  logic       sda_pull, irq_n;

  assign sda_line = sda_m & ~sda_pull;

  cifh_host_regs #(.HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sel_i(sel),
    .pres_i(pres), .io_lvl_i(io), .active_i(act), .sup_fault_i(supf),
    .prot_fault_i(protf), .mute_i(mute), .early_i(early),
    .ctrl_o(ctrl), .sda_pull_o(sda_pull), .irq_n_o(irq_n));

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic a, e, m, p, s, i, c, r);
    return {a, e, m, p, s, i, c, r};
  endfunction

  task automatic hq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; hq(Q);
    sda_m = 0; hq(Q);
    scl_m = 0; hq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; hq(Q);
    scl_m = 1; hq(Q);
    sda_m = 1; hq(2 * Q);
  endtask

  task automatic bus_bit(input logic b, input bit glitch, output logic r);
    sda_m = b;
    if (glitch) begin
      hq(5); scl_m = 1; hq(5); scl_m = 0; hq(Q - 10);
    end else hq(Q);
    scl_m = 1; hq(Q);
    r = sda_line; hq(Q);
    scl_m = 0; hq(Q);
  endtask

  task automatic do_write(input logic [6:0] a7, input logic [7:0] d,
                          input bit glitch, output logic ack_a);
    logic r;
    bus_start();
    for (int i = 6; i >= 0; i--) bus_bit(a7[i], 0, r);
    bus_bit(1'b0, 0, r);
    bus_bit(1'b1, 0, ack_a);
    if (ack_a == 1'b0) begin
      for (int i = 7; i >= 0; i--) bus_bit(d[i], glitch && i == 3, r);
      bus_bit(1'b1, 0, r);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a7, output logic ack_a, output logic [7:0] d);
    logic r;
    bus_start();
    for (int i = 6; i >= 0; i--) bus_bit(a7[i], 0, r);
    bus_bit(1'b1, 0, r);
    bus_bit(1'b1, 0, ack_a);
    d = 8'hFF;
    if (ack_a == 1'b0) begin
      for (int i = 7; i >= 0; i--) begin
        bus_bit(1'b1, 0, r);
        d[i] = r;
      end
      bus_bit(1'b1, 0, r);
    end
    bus_stop();
  endtask

  task automatic pulse_mute();  mute = 1;  hq(1); mute = 0;  hq(2); endtask
  task automatic pulse_early(); early = 1; hq(1); early = 0; hq(2); endtask
  task automatic pulse_prot();  protf = 1; hq(1); protf = 0; hq(2); endtask

  function automatic logic [6:0] my_addr();
    return 7'h20 | {4'b0, sel};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d, exp_ctrl;
    int unsigned seed;
    seed = $urandom(32'd2024);
    hq(5); rst_n = 1; hq(5);

    chk("R2 reset ctrl", ctrl, 8'h00);
    chk("R8 reset irq", {7'd0, irq_n}, 8'h01);
    chk("R1 reset sda", {7'd0, sda_pull}, 8'h00);
    exp_ctrl = 8'h00;

    // R1/R2 random writes to matching and non-matching addresses
    for (int n = 0; n < 12; n++) begin
      logic [6:0] tgt;
      logic [7:0] dat;
      bit hit;
      sel = 3'($urandom);
      hit = ($urandom % 10) < 7;
      dat = 8'($urandom);
      tgt = hit ? my_addr() : (7'h20 | {4'b0, sel ^ 3'(1 + $urandom % 7)});
      do_write(tgt, dat, 0, ack);
      if (hit) exp_ctrl = dat;
      chk(hit ? "R1 ack match" : "R1 nack other", {7'd0, ack}, {7'd0, !hit});
      chk("R2 ctrl after write", ctrl, exp_ctrl);
    end

    // R3 status layout with live inputs only
    act = 1; io = 0; pres = 0; hq(4);
    do_read(my_addr(), ack, d);
    chk("R3 status live", d, exp_status(1, 0, 0, 0, 0, 0, 0, 0));
    act = 0; io = 1; hq(4);
    do_read(my_addr(), ack, d);
    chk("R3 status io", d, exp_status(0, 0, 0, 0, 0, 1, 0, 0));
    chk("R8 irq quiet", {7'd0, irq_n}, 8'h01);

    // R4 presence change
    pres = 1; hq(4);
    chk("R8 irq on presence", {7'd0, irq_n}, 8'h00);
    do_read(my_addr(), ack, d);
    chk("R4 change reported", d, exp_status(0, 0, 0, 0, 0, 1, 1, 1));
    chk("R8 irq after read", {7'd0, irq_n}, 8'h01);
    do_read(my_addr(), ack, d);
    chk("R4 change cleared", d, exp_status(0, 0, 0, 0, 0, 1, 0, 1));

    // R6 protection, R1 wrong address leaves it latched
    pulse_prot();
    do_read(my_addr() ^ 7'h01, ack, d);
    chk("R1 nack read", {7'd0, ack}, 8'h01);
    chk("R1 flag kept", {7'd0, irq_n}, 8'h00);
    do_read(my_addr(), ack, d);
    chk("R6 prot reported", d, exp_status(0, 0, 0, 1, 0, 1, 0, 1));
    chk("R6 irq released", {7'd0, irq_n}, 8'h01);

    // R7 mute cleared by session start, early cleared by read
    do_write(my_addr(), 8'h00, 0, ack);
    pulse_mute();
    chk("R7 mute irq", {7'd0, irq_n}, 8'h00);
    do_write(my_addr(), 8'h01, 0, ack);
    chk("R7 session clears mute", {7'd0, irq_n}, 8'h01);
    do_read(my_addr(), ack, d);
    chk("R7 mute gone", d, exp_status(0, 0, 0, 0, 0, 1, 0, 1));
    pulse_early();
    do_read(my_addr(), ack, d);
    chk("R7 early reported", d, exp_status(0, 1, 0, 0, 0, 1, 0, 1));
    do_read(my_addr(), ack, d);
    chk("R7 early cleared", d, exp_status(0, 0, 0, 0, 0, 1, 0, 1));

    // R5 supply fault and hold window
    supf = 1; hq(100);
    chk("R5 irq during fault", {7'd0, irq_n}, 8'h00);
    supf = 0; hq(2);
    do_read(my_addr(), ack, d);
    chk("R5 supply reported", d, exp_status(0, 0, 0, 0, 1, 1, 0, 1));
    chk("R5 irq held", {7'd0, irq_n}, 8'h00);
    hq(HOLD);
    chk("R5 irq after hold", {7'd0, irq_n}, 8'h01);

    // R9 event after status capture survives the clear
    fork
      do_read(my_addr(), ack, d);
      begin hq(1500); pulse_prot(); end
    join
    chk("R9 late event not in byte", d, exp_status(0, 0, 0, 0, 0, 1, 0, 1));
    chk("R9 irq still low", {7'd0, irq_n}, 8'h00);
    do_read(my_addr(), ack, d);
    chk("R9 late event next read", d, exp_status(0, 0, 0, 1, 0, 1, 0, 1));

    // R10 short SCL spike inside a data byte
    do_write(my_addr(), 8'hA5, 1, ack);
    chk("R10 spike ignored", ctrl, 8'hA5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule